// File: doc/BRIEF.md
# DMA Bridge Interrupt Aggregator

This block collects ten single-cycle event pulses from a DMA bridge and presents them to software through one 32-bit control and status word. Two of the events come from a USB transfer path: transfer complete and address error. The other eight come from two audio channels. Each channel has a play direction and a record direction, and each direction reports both a full-buffer event and a half-buffer event. Every event has a sticky pending flag and an enable flag. A pending flag is set by its pulse and stays set until software writes a zero to it.

The enabled, pending events are merged onto three level-sensitive interrupt request lines:

- Line 0 carries the USB address error alone.
- Line 1 carries every completion event: USB transfer done and the four audio full-buffer events.
- Line 2 carries the four audio half-buffer events.

Software reads the whole word, services what it finds, and acknowledges chosen events by writing the read value back with only those pending bits cleared. Writing a one to a pending bit leaves it unchanged, so this write-back cannot clear anything else. The register port has no address. Decoding the address is left to the surrounding bus logic.

Top module: `dmab_irq_agg`

## Requirements
- R1: A pulse on `evt_pulse[n]` sets pending bit P(n) in `reg_rdata` at the next clock edge. P(0)=0 and P(1)=1. For n from 2 to 9, P(n)=n+14. Event order: 0 USB done, 1 USB address error, 2 ch0 play full, 3 ch0 play half, 4 ch0 record full, 5 ch0 record half, 6 to 9 the same four events for ch1.
- R2: A pending bit holds its value while no write occurs. It also holds when a write carries a 1 in its position.
- R3: A write with a 0 at position P(n) clears pending bit n at that clock edge.
- R4: If an event pulse arrives in the same cycle as a write that clears its pending bit, the bit ends up set.
- R5: Every write loads enable bit n from `reg_wdata` position E(n). E(0)=8 and E(1)=9. For n from 2 to 9, E(n)=n+22. Without a write, the enable bits hold.
- R6: `irq_line[0]` is high exactly when event 1 is both pending and enabled.
- R7: `irq_line[1]` is the OR of (pending AND enabled) over events 0, 2, 4, 6 and 8.
- R8: `irq_line[2]` is the OR of (pending AND enabled) over events 3, 5, 7 and 9.
- R9: An event whose enable bit is 0 still sets its pending bit, but it drives no interrupt line.
- R10: Bits 15:10 and 7:2 of `reg_rdata` always read 0, and writes to those bits have no effect.
- R11: Reset clears every pending and enable bit, so `reg_rdata` is 0 and all three lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control/status word |
| evt_pulse | input | 10 | Single-cycle event pulses, bit n is event n |
| irq_line | output | 3 | Level interrupt requests, lines 0 to 2 |

## Verification
Every pending and enable flag appears directly in `reg_rdata`. A flag that is set, lost or left uncleared therefore shows at the port one clock edge after the pulse or write that should have changed it. An event wired to the wrong group, or a mapping error between pending and enable bits, shows on `irq_line` in that same cycle. The checks pair each event with enables deliberately switched off and on. This separates a flag that is correct but masked from a line that is miswired. The same-edge collision of a pulse with a clearing write is driven on purpose, because a clear that takes priority would silently drop an event.

// File: rtl/dmab_irq_pkg.sv
package dmab_irq_pkg;

    localparam int N_EVT         = 10;
    localparam int N_LINE        = 3;
    localparam int REG_W         = 32;
    localparam int N_USB         = 2;
    localparam int USB_EN_BASE   = 8;
    localparam int AUD_STAT_BASE = 16;
    localparam int AUD_EN_BASE   = 24;

    localparam int LINE_UERR = 0;
    localparam int LINE_FULL = 1;
    localparam int LINE_HALF = 2;

    typedef logic [N_EVT-1:0]  evt_vec_t;
    typedef logic [REG_W-1:0]  reg_word_t;
    typedef logic [N_LINE-1:0] line_vec_t;

    // Bit position of the pending flag of event n.
    function automatic int stat_pos(input int n);
        return (n < N_USB) ? n : AUD_STAT_BASE + n - N_USB;
    endfunction

    // Bit position of the enable flag of event n.
    function automatic int en_pos(input int n);
        return (n < N_USB) ? USB_EN_BASE + n : AUD_EN_BASE + n - N_USB;
    endfunction

    // Interrupt line that event n feeds.
    function automatic int line_of(input int n);
        if (n == 1)
            return LINE_UERR;
        else if (n == 0)
            return LINE_FULL;
        else if (((n - N_USB) % 2) == 0)
            return LINE_FULL;
        else
            return LINE_HALF;
    endfunction

    // Events belonging to line l.
    function automatic evt_vec_t line_mask(input int l);
        evt_vec_t m;
        m = '0;
        for (int n = 0; n < N_EVT; n++)
            if (line_of(n) == l) m[n] = 1'b1;
        return m;
    endfunction

    // Register bits that hold a flag.
    function automatic reg_word_t used_mask();
        reg_word_t m;
        m = '0;
        for (int n = 0; n < N_EVT; n++) begin
            m[stat_pos(n)] = 1'b1;
            m[en_pos(n)]   = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dmab_flag_cell.sv
module dmab_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_stat_bit,
    input  logic wr_en_bit,
    input  logic evt,
    output logic stat_q,
    output logic en_q
);

    logic stat_d;
    logic en_d;

    // A write of 0 clears the flag; an event in the same cycle wins.
    always_comb begin
        stat_d = stat_q;
        if (wr_en && !wr_stat_bit)
            stat_d = 1'b0;
        if (evt)
            stat_d = 1'b1;
        en_d = wr_en ? wr_en_bit : en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            stat_q <= stat_d;
            en_q   <= en_d;
        end
    end

endmodule

// File: rtl/dmab_line_merge.sv
module dmab_line_merge
    import dmab_irq_pkg::*;
(
    input  evt_vec_t  stat,
    input  evt_vec_t  en,
    output line_vec_t line
);

    evt_vec_t active;

    assign active = stat & en;

    for (genvar l = 0; l < N_LINE; l++) begin : g_line
        localparam evt_vec_t MASK = line_mask(l);
        assign line[l] = |(active & MASK);
    end

endmodule

// File: rtl/dmab_irq_agg.sv
module dmab_irq_agg
    import dmab_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [9:0]  evt_pulse,
    output logic [2:0]  irq_line
);

    localparam reg_word_t USED = used_mask();

    evt_vec_t stat_q;
    evt_vec_t en_q;
    logic     unused_wbits;

    assign unused_wbits = ^(reg_wdata & ~USED);

    for (genvar n = 0; n < N_EVT; n++) begin : g_evt
        localparam int SP = stat_pos(n);
        localparam int EP = en_pos(n);
        dmab_flag_cell cell_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (reg_we),
            .wr_stat_bit (reg_wdata[SP]),
            .wr_en_bit   (reg_wdata[EP]),
            .evt         (evt_pulse[n]),
            .stat_q      (stat_q[n]),
            .en_q        (en_q[n])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int n = 0; n < N_EVT; n++) begin
            reg_rdata[stat_pos(n)] = stat_q[n];
            reg_rdata[en_pos(n)]   = en_q[n];
        end
    end

    dmab_line_merge merge_i (
        .stat (stat_q),
        .en   (en_q),
        .line (irq_line)
    );

endmodule

// File: rtl/dmab_irq_agg_chk.sv
module dmab_irq_agg_chk
    import dmab_irq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [9:0]  evt_pulse,
    input logic [2:0]  irq_line
);

    localparam reg_word_t USED = used_mask();

    evt_vec_t act;
    always_comb
        for (int n = 0; n < N_EVT; n++)
            act[n] = reg_rdata[stat_pos(n)] & reg_rdata[en_pos(n)];

    for (genvar n = 0; n < N_EVT; n++) begin : g_evt
        localparam int SP = stat_pos(n);
        localparam int EP = en_pos(n);

        p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
            evt_pulse[n] |=> reg_rdata[SP]);

        p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt_pulse[n] && (!reg_we || reg_wdata[SP]))
            |=> (reg_rdata[SP] == $past(reg_rdata[SP])));

        // Also covers R4: clear only when no pulse in the same cycle.
        p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && !reg_wdata[SP] && !evt_pulse[n]) |=> !reg_rdata[SP]);

        p_en_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
            reg_we |=> (reg_rdata[EP] == $past(reg_wdata[EP])));

        p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_we |=> $stable(reg_rdata[EP]));
    end

    p_line0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line[0] == act[1]);

    p_line1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line[1] == (act[0] | act[2] | act[4] | act[6] | act[8]));

    p_line2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line[2] == (act[3] | act[5] | act[7] | act[9]));

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~USED) == '0);

endmodule

bind dmab_irq_agg dmab_irq_agg_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_pulse (evt_pulse),
    .irq_line  (irq_line)
);

// File: tb/dmab_irq_agg_tb.sv
module dmab_irq_agg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [9:0]  evt_pulse = '0;
    logic [2:0]  irq_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dmab_irq_agg dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .irq_line  (irq_line)
    );

    // {we, wdata, evt, expected rdata, expected irq}
    localparam int NV = 12;
    localparam logic [77:0] VEC [NV] = '{
        {1'b1, 32'hFFFF_FFFF, 10'h000, 32'hFF00_0300, 3'b000},
        {1'b0, 32'h0000_0000, 10'h004, 32'hFF01_0300, 3'b010},
        {1'b0, 32'h0000_0000, 10'h008, 32'hFF03_0300, 3'b110},
        {1'b0, 32'h0000_0000, 10'h002, 32'hFF03_0302, 3'b111},
        {1'b1, 32'hFF02_0302, 10'h000, 32'hFF02_0302, 3'b101},
        {1'b1, 32'h00FF_00FF, 10'h000, 32'h0002_0002, 3'b000},
        {1'b0, 32'h0000_0000, 10'h3FF, 32'h00FF_0003, 3'b000},
        {1'b1, 32'hFFFF_FFFF, 10'h000, 32'hFFFF_0303, 3'b111},
        {1'b1, 32'hFF00_0300, 10'h010, 32'hFF04_0300, 3'b010},
        {1'b1, 32'hFF00_0200, 10'h000, 32'hFF00_0200, 3'b000},
        {1'b0, 32'h0000_0000, 10'h001, 32'hFF00_0201, 3'b000},
        {1'b1, 32'hFF00_0301, 10'h000, 32'hFF00_0301, 3'b010}
    };
    localparam string TAG [NV] = '{
        "R5 R10 R2", "R1 R7", "R1 R8", "R1 R6",
        "R3 R2", "R5 R2", "R9 R1", "R5 R6 R7 R8",
        "R4 R3", "R3 R5", "R9", "R5 R7"
    };

    task automatic check(input string req, input logic [31:0] rd_exp,
                         input logic [2:0] irq_exp);
        checks++;
        if (reg_rdata !== rd_exp || irq_line !== irq_exp) begin
            fails++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     req, reg_rdata, irq_line, rd_exp, irq_exp);
        end
    endtask

    // Drive on a falling edge, sample on the next falling edge.
    task automatic step(input logic we, input logic [31:0] wd,
                        input logic [9:0] ev);
        @(negedge clk);
        reg_we    = we;
        reg_wdata = wd;
        evt_pulse = ev;
        @(negedge clk);
        reg_we    = 1'b0;
        reg_wdata = '0;
        evt_pulse = '0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: rdata=%h irq=%b expected completion",
                     reg_rdata, irq_line);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset", 32'h0, 3'b000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][77], VEC[i][76:45], VEC[i][44:35]);
            check(TAG[i], VEC[i][34:3], VEC[i][2:0]);
        end

        // R11: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 midrun", 32'h0, 3'b000);
        rst_n = 1'b1;

        // R8: event 9 alone reaches line 2; R10 unused write bits ignored
        step(1'b1, 32'hFFFF_FCFC, 10'h000);
        check("R10 R5", 32'hFF00_0000, 3'b000);
        step(1'b0, 32'h0, 10'h200);
        check("R8 event9", 32'hFF80_0000, 3'b100);

        // R7: event 8 alone reaches line 1
        step(1'b0, 32'h0, 10'h100);
        check("R7 event8", 32'hFFC0_0000, 3'b110);

        // R2: idle cycles keep pending state
        step(1'b0, 32'h0, 10'h000);
        check("R2 idle", 32'hFFC0_0000, 3'b110);

        // R3: clear event 9 only by write-back
        step(1'b1, 32'hFF40_0000, 10'h000);
        check("R3 writeback", 32'hFF40_0000, 3'b010);

        // R6: USB error with its enable only
        step(1'b1, 32'h0000_0200, 10'h002);
        check("R6 usb err", 32'h0000_0202, 3'b001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule